// File: doc/BRIEF.md
# Oversampling ADC readout sequencer

This block runs a serial SAR converter that averages several conversions internally before it returns one result. The block derives a square synchronization clock from the system clock. On each rising edge of that clock it issues a one-cycle conversion-start pulse. It passes the converter's busy line through a chain of flip-flops and counts the falling edges of the synchronized copy. When a programmable number of conversions has completed, it loads a one-shot bit counter. While that counter is non-zero, the serial clock follows the synchronization clock, so the burst has exactly as many serial clock periods as the count loaded.

The returned bits arrive most significant first. They are collected left-aligned in a frame register. When the last bit has been taken, the word is presented together with a one-cycle valid strobe. The oversampling ratio and the frame length are sampled when each group of conversions begins, so a host can write new values at any time without corrupting the group that is in flight.

Top module: `adc_os_seq`

## Requirements
- R1: The synchronization clock has a period of 2*HALF system clocks. `adc_cnv` is a single-cycle pulse that is registered after each rising edge of that clock, but only while no readout burst is active.
- R2: `adc_busy` passes through two synchronizing flip-flops and a third edge-detect flip-flop before it is counted. Each synchronized falling edge counts as one completed conversion. After the group's ratio N of such edges, a burst starts and the conversion count restarts from zero.
- R3: A burst contains exactly B serial clock pulses. Each pulse is high for HALF system clocks and aligned to the synchronization clock. No `adc_cnv` pulse occurs while the burst runs.
- R4: `adc_sdo` is sampled on each falling edge of `adc_sck`, with the first bit stored in bit FW-1 of `dout` and each later bit one position lower. The FW-B low bits of `dout` read zero.
- R5: `dout_vld` is high for exactly one cycle, in the cycle in which `adc_sck` falls for the last time in the burst. `dout` then holds the new word.
- R6: N and B are sampled at reset and at every burst start, and those values apply to the group that begins there. A value written after a burst starts first takes effect in the group after the next burst.
- R7: A frame-length setting of 0, or one above FW, gives B = FW. A ratio setting of 0 gives N = 1. A ratio of 1 and a length of 1 are legal.
- R8: Synchronous reset clears both counters, holds `adc_sck` and `adc_cnv` low, deasserts `dout_vld` and clears `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ratio | input | NW | Oversampling ratio N |
| cfg_bits | input | $clog2(FW+1) | Bits per frame B |
| adc_busy | input | 1 | Converter busy line, low when the result is ready |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cnv | output | 1 | Conversion start pulse |
| adc_sck | output | 1 | Serial clock to the converter |
| dout | output | FW | Received word, left-aligned |
| dout_vld | output | 1 | One-cycle strobe, new word present |

## Verification
The bench runs seven groups with a converter model that answers every start pulse with a short busy period and shifts its word out on serial clock rising edges. The groups use ratios of 1, 2, 3 and 4 and frame lengths of 1, 16, 24 and 32, plus a length of 0 that must become 32. Each group uses a different data pattern, so a wrong bit order, a shift of one place or stale low bits shows up in the word. The bench counts start pulses and serial clock pulses between strobes, which separates an off-by-one in the conversion count from one in the bit count. Configuration writes are placed right after a strobe. This separates capture at the group start from capture at the burst or a live read.

// File: rtl/adc_os_seq.sv
module adc_os_seq #(
  parameter int HALF = 4,
  parameter int NW   = 16,
  parameter int FW   = 32,
  localparam int BW  = $clog2(FW + 1),
  localparam int PW  = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] cfg_ratio,
  input  logic [BW-1:0] cfg_bits,
  input  logic          adc_busy,
  input  logic          adc_sdo,
  output logic          adc_cnv,
  output logic          adc_sck,
  output logic [FW-1:0] dout,
  output logic          dout_vld
);

  logic [PW-1:0] pc;
  logic          sp;
  logic [2:0]    bsy;
  logic [NW-1:0] cc, n_grp;
  logic [BW-1:0] bits_grp, bits_run, bcnt;
  logic [FW-1:0] sr, sr_nx;

  wire tick = (pc == PW'(HALF - 1));
  wire rise = tick & ~sp;
  wire fall = tick & sp;

  wire bfall = bsy[2] & ~bsy[1];
  wire gate  = (bcnt != '0);

  wire [NW-1:0] n_cfg    = (cfg_ratio == '0) ? NW'(1) : cfg_ratio;
  wire [BW-1:0] bits_cfg = (cfg_bits == '0 || cfg_bits > BW'(FW)) ? BW'(FW) : cfg_bits;

  wire grp_done = bfall && ({1'b0, cc} + (NW+1)'(1) >= {1'b0, n_grp});
  wire fire     = grp_done && !gate;

  wire [BW-1:0] idx = bits_run - bcnt;
  wire [BW-1:0] pos = BW'(FW - 1) - idx;

  assign sr_nx = sr | ({{(FW-1){1'b0}}, adc_sdo} << pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      sp <= 1'b0;
    end else if (tick) begin
      pc <= '0;
      sp <= ~sp;
    end else begin
      pc <= pc + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bsy <= '0;
    else     bsy <= {bsy[1:0], adc_busy};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc       <= '0;
      n_grp    <= n_cfg;
      bits_grp <= bits_cfg;
      bits_run <= '0;
      bcnt     <= '0;
      sr       <= '0;
      adc_sck  <= 1'b0;
      adc_cnv  <= 1'b0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      adc_cnv  <= rise & ~gate;
      dout_vld <= 1'b0;
      if (bfall) cc <= grp_done ? '0 : cc + NW'(1);
      if (fire) begin
        bcnt     <= bits_grp;
        bits_run <= bits_grp;
        sr       <= '0;
        n_grp    <= n_cfg;
        bits_grp <= bits_cfg;
      end else if (gate) begin
        if (rise) begin
          adc_sck <= 1'b1;
        end else if (fall && adc_sck) begin
          adc_sck <= 1'b0;
          sr      <= sr_nx;
          bcnt    <= bcnt - BW'(1);
          if (bcnt == BW'(1)) begin
            dout_vld <= 1'b1;
            dout     <= sr_nx;
          end
        end
      end
    end
  end

endmodule

// File: rtl/adc_os_seq_chk.sv
module adc_os_seq_chk (
  input logic clk,
  input logic rst,
  input logic adc_cnv,
  input logic adc_sck,
  input logic dout_vld
);

  // R5
  vld_one_cycle_chk: assert property (@(posedge clk) disable iff (rst) dout_vld |=> !dout_vld);

  // R5
  vld_at_fall_chk: assert property (@(posedge clk) disable iff (rst) dout_vld |-> (!adc_sck && $past(adc_sck)));

  // R1
  cnv_pulse_chk: assert property (@(posedge clk) disable iff (rst) adc_cnv |=> !adc_cnv);

  // R3
  cnv_quiet_chk: assert property (@(posedge clk) disable iff (rst) adc_sck |-> !adc_cnv);

  // R3
  sck_hold_chk: assert property (@(posedge clk) disable iff (rst) $rose(adc_sck) |=> adc_sck);

  // R8
  rst_clear_chk: assert property (@(posedge clk) rst |=> (!adc_sck && !dout_vld && !adc_cnv));

endmodule

bind adc_os_seq adc_os_seq_chk u_chk (
  .clk(clk), .rst(rst), .adc_cnv(adc_cnv), .adc_sck(adc_sck), .dout_vld(dout_vld)
);

// File: tb/sim_adc_os_seq.sv
module sim_adc_os_seq;
  localparam int FW = 32;
  localparam int BW = $clog2(FW + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] cfg_ratio = 16'd4;
  logic [BW-1:0] cfg_bits = BW'(24);
  logic adc_busy = 1'b0, adc_sdo = 1'b0;
  logic adc_cnv, adc_sck, dout_vld;
  logic [FW-1:0] dout;

  int n_chk = 0, n_fail = 0;
  int cnv_cnt = 0, sck_cnt = 0, bsy_left = 0, k = 0;
  logic sck_prev = 1'b0;
  logic [FW-1:0] adc_word = '0;

  always #10 clk = ~clk;

  adc_os_seq u0 (
    .clk(clk), .rst(rst), .cfg_ratio(cfg_ratio), .cfg_bits(cfg_bits),
    .adc_busy(adc_busy), .adc_sdo(adc_sdo), .adc_cnv(adc_cnv), .adc_sck(adc_sck),
    .dout(dout), .dout_vld(dout_vld)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (adc_cnv) begin
        cnv_cnt++;
        adc_busy = 1'b1;
        bsy_left = 3;
      end else if (bsy_left > 0) begin
        bsy_left--;
        if (bsy_left == 0) adc_busy = 1'b0;
      end
      if (adc_sck && !sck_prev) begin
        sck_cnt++;
        adc_sdo = (k < FW) ? adc_word[FW-1-k] : 1'b0;
        k++;
      end
    end
    sck_prev = adc_sck;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R8 sck", 64'(adc_sck), 0);
    check("R8 vld", 64'(dout_vld), 0);
    check("R8 dout", 64'(dout), 0);
    check("R8 cnv", 64'(adc_cnv), 0);
    rst = 1'b0;
  endtask

  task automatic t_group(input string tag, input int n, input int b, input logic [FW-1:0] w);
    logic [FW-1:0] mask;
    int guard;
    adc_word = w;
    mask = (b >= FW) ? '1 : ~((FW'(1) << (FW - b)) - FW'(1));
    guard = 0;
    @(negedge clk);
    while (!dout_vld && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (!dout_vld) begin
      check({tag, " watchdog"}, 64'(1), 0);
    end else begin
      check({tag, " R4 word"}, 64'(dout), 64'(w & mask));
      check({tag, " R3 sck count"}, 64'(sck_cnt), 64'(b));
      check({tag, " R2 cnv count"}, 64'(cnv_cnt), 64'(n));
      cnv_cnt = 0;
      sck_cnt = 0;
      k = 0;
      @(negedge clk);
      check({tag, " R5 vld width"}, 64'(dout_vld), 0);
      check({tag, " R5 dout hold"}, 64'(dout), 64'(w & mask));
    end
  endtask

  initial begin
    t_reset();
    t_group("g1", 4, 24, 32'hA5C3_F01E);
    cfg_ratio = 16'd1; cfg_bits = BW'(32);
    t_group("g2 R6 old", 4, 24, 32'h1234_5678);
    cfg_ratio = 16'd3; cfg_bits = BW'(1);
    t_group("g3 R6 new", 1, 32, 32'hDEAD_BEEF);
    cfg_ratio = 16'd2; cfg_bits = BW'(0);
    t_group("g4 R7 n1", 3, 1, 32'h8000_0001);
    cfg_ratio = 16'd0; cfg_bits = BW'(16);
    t_group("g5 R7 b1", 2, 32, 32'h0F0F_3C3C);
    t_group("g6 R7 b0", 1, 16, 32'hC001_D00D);
    t_group("g7 R7 n0", 1, 16, 32'h5555_AAAA);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule